// File: doc/BRIEF.md
# Pulsed Overload Protection Controller

This block decides whether a supply output stage may drive its load. It watches an overcurrent comparator and two junction-temperature comparators, and it produces one output-enable plus two status bits for a host-visible register: an overload flag and a thermal flag. A master enable from the register gates everything. A mode input selects one of two ways to handle overload. In clamp mode the analog limiter holds the current and the flag only reports that state. In pulsed mode an overload shuts the output off for a long interval and then re-enables it for a short trial window. This repeats until a whole trial window passes with no overload.

The off interval is `OFF_CYC` clock cycles. The trial window is `OFF_CYC / ON_DIV` cycles, a tenth by default. Both are parameters so that a simulation can use short values. The inputs can pass through `SYNC_STAGES` resynchronising flops (0 removes them). Each requirement below gives its timing for `SYNC_STAGES = 0`. Every other stage count delays the inputs by the same amount.

Top module: `ovl_guard`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it, `out_en`, `ovl_flag` and `therm_flag` are all 0.
- R2: A 0 on `pwr_en` drives `out_en` to 0 in the same cycle and abandons any off or trial phase. Once `pwr_en` returns to 1, `out_en` is 1 and `ovl_flag` is 0.
- R3: In pulsed mode (`clamp_static` = 0), an overload sampled while running and enabled drops `out_en` on the next cycle. `out_en` then stays low for exactly `OFF_CYC` cycles, and `ovl_flag` is 1 for the whole interval.
- R4: After the off interval, `out_en` is 1 for a trial window of `OFF_CYC/ON_DIV` cycles, and `ovl_flag` stays 1 throughout.
- R5: If no overload is sampled during the trial window, `ovl_flag` returns to 0 on the cycle after the window ends, and `out_en` stays 1.
- R6: An overload sampled in any cycle of the trial window, including a single-cycle pulse early in it, starts a new off interval right after the window ends.
- R7: In clamp mode (`clamp_static` = 1), `out_en` is never dropped for overload. `ovl_flag` follows `ovl_det` one cycle later.
- R8: Setting `clamp_static` to 1 during an off interval or a trial window ends the cycle, so `out_en` is 1 on the next cycle.
- R9: `temp_hot` = 1 sets `therm_flag` and drops `out_en` on the next cycle. Both stay that way until `temp_cool` = 1 is sampled. When both temperature inputs are 1, the hot input wins.
- R10: While `therm_flag` is set or `pwr_en` is 0, an overload does not start an off interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_en | input | 1 | Master enable for the power stages |
| clamp_static | input | 1 | 1 selects clamp mode, 0 selects pulsed mode |
| ovl_det | input | 1 | Overcurrent comparator output |
| temp_hot | input | 1 | Junction above the upper thermal threshold |
| temp_cool | input | 1 | Junction below the lower thermal threshold |
| out_en | output | 1 | Output stage enable |
| ovl_flag | output | 1 | Overload status bit |
| therm_flag | output | 1 | Thermal shutdown status bit |

## Verification
The bound checker checks these rules on every cycle:
- Entry into the off phase after an overload.
- The flag staying high throughout the off phase.
- The re-trigger when an overload arrives at the last trial cycle.
- `out_en` held high once clamp mode is set.
- Thermal set and hold.
- The return to the running state when disabled or hot.

The directed scenarios cover what a one-cycle property cannot. These are the exact length of the off interval and of the trial window, the fact that an overload early in the window is remembered until the window ends, the clean recovery that clears the flag, and the full thermal hysteresis sequence.

// File: rtl/prot_pkg.sv
package prot_pkg;

   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_OFF   = 2'd1,
      ST_RETRY = 2'd2
   } ovl_st_e;

   localparam int unsigned SYNC_W = 5;

endpackage

// File: rtl/prot_sync.sv
module prot_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES == 0) begin : g_pass
      assign q = d;
   end else begin : g_ff
      logic [W-1:0] pipe [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
         end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
         end
      end

      assign q = pipe[STAGES-1];
   end

endmodule

// File: rtl/prot_timer.sv
module prot_timer #(
   parameter int unsigned CW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          done
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/prot_therm.sv
module prot_therm (
   input  logic clk,
   input  logic rst_n,
   input  logic hot,
   input  logic cool,
   output logic lock
);

   logic lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    lock_q <= 1'b0;
      else if (hot)  lock_q <= 1'b1;
      else if (cool) lock_q <= 1'b0;
   end

   assign lock = lock_q;

endmodule

// File: rtl/prot_ovl_fsm.sv
module prot_ovl_fsm
   import prot_pkg::*;
#(
   parameter int unsigned OFF_CYC = 1000,
   parameter int unsigned ON_DIV  = 10
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    en,
   input  logic    stat,
   input  logic    ovl,
   input  logic    lock,
   output ovl_st_e st,
   output logic    win_end,
   output logic    flag
);

   localparam int unsigned ON_CYC = OFF_CYC / ON_DIV;
   localparam int unsigned CW     = $clog2(OFF_CYC);
   localparam logic [CW-1:0] OFF_LD = CW'(OFF_CYC - 1);
   localparam logic [CW-1:0] ON_LD  = CW'(ON_CYC - 1);

   ovl_st_e       st_q, st_d;
   logic          seen_q, seen_d;
   logic          stat_q;
   logic          tm_load;
   logic [CW-1:0] tm_val;
   logic          tm_done;

   prot_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tm_load),
      .load_val (tm_val),
      .done     (tm_done)
   );

   always_comb begin
      st_d    = st_q;
      seen_d  = seen_q;
      tm_load = 1'b0;
      tm_val  = OFF_LD;
      if (!en || lock) begin
         st_d   = ST_RUN;
         seen_d = 1'b0;
      end else begin
         unique case (st_q)
            ST_RUN: begin
               if (!stat && ovl) begin
                  st_d    = ST_OFF;
                  tm_load = 1'b1;
               end
            end
            ST_OFF: begin
               if (stat) begin
                  st_d = ST_RUN;
               end else if (tm_done) begin
                  st_d    = ST_RETRY;
                  tm_load = 1'b1;
                  tm_val  = ON_LD;
                  seen_d  = 1'b0;
               end
            end
            ST_RETRY: begin
               if (stat) begin
                  st_d   = ST_RUN;
                  seen_d = 1'b0;
               end else begin
                  if (ovl) seen_d = 1'b1;
                  if (tm_done) begin
                     seen_d = 1'b0;
                     if (seen_q || ovl) begin
                        st_d    = ST_OFF;
                        tm_load = 1'b1;
                     end else begin
                        st_d = ST_RUN;
                     end
                  end
               end
            end
            default: st_d = ST_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_RUN;
         seen_q <= 1'b0;
         stat_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         seen_q <= seen_d;
         stat_q <= en & ~lock & stat & ovl;
      end
   end

   assign st      = st_q;
   assign win_end = (st_q == ST_RETRY) && tm_done;
   assign flag    = (st_q != ST_RUN) | stat_q;

endmodule

// File: rtl/ovl_guard.sv
module ovl_guard
   import prot_pkg::*;
#(
   parameter int unsigned OFF_CYC     = 1000,
   parameter int unsigned ON_DIV      = 10,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_en,
   input  logic clamp_static,
   input  logic ovl_det,
   input  logic temp_hot,
   input  logic temp_cool,
   output logic out_en,
   output logic ovl_flag,
   output logic therm_flag
);

   if (ON_DIV < 2) begin : g_bad_div
      $error("ovl_guard: ON_DIV must be at least 2");
   end
   if (OFF_CYC < 2 * ON_DIV) begin : g_bad_off
      $error("ovl_guard: OFF_CYC must give a trial window of two or more cycles");
   end

   logic [SYNC_W-1:0] raw, syn;
   logic    en_s, stat_s, ovl_s, hot_s, cool_s;
   logic    lock;
   ovl_st_e st_q;
   logic    win_end;
   logic    flag;

   assign raw = {pwr_en, clamp_static, ovl_det, temp_hot, temp_cool};

   prot_sync #(.STAGES(SYNC_STAGES), .W(SYNC_W)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw),
      .q     (syn)
   );

   assign {en_s, stat_s, ovl_s, hot_s, cool_s} = syn;

   prot_therm u_therm (
      .clk   (clk),
      .rst_n (rst_n),
      .hot   (hot_s),
      .cool  (cool_s),
      .lock  (lock)
   );

   prot_ovl_fsm #(.OFF_CYC(OFF_CYC), .ON_DIV(ON_DIV)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en_s),
      .stat    (stat_s),
      .ovl     (ovl_s),
      .lock    (lock),
      .st      (st_q),
      .win_end (win_end),
      .flag    (flag)
   );

   assign out_en     = en_s & ~lock & (st_q != ST_OFF);
   assign ovl_flag   = flag;
   assign therm_flag = lock;

endmodule

// File: rtl/ovl_guard_chk.sv
module ovl_guard_chk
   import prot_pkg::*;
(
   input logic    clk,
   input logic    rst_n,
   input logic    en,
   input logic    stat,
   input logic    ovl,
   input logic    hot,
   input logic    cool,
   input ovl_st_e st,
   input logic    win_end,
   input logic    out_en,
   input logic    ovl_flag,
   input logic    therm_flag
);

   assert_off_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !therm_flag && !stat && ovl && st == ST_RUN) |=> (st == ST_OFF && !out_en));

   assert_off_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_OFF) |-> ovl_flag);

   assert_retrigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (win_end && en && !therm_flag && !stat && ovl) |=> (st == ST_OFF));

   assert_clamp_keeps_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(stat) && $past(en) && $past(!therm_flag) && en && !therm_flag) |-> out_en);

   assert_hot_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hot |=> (therm_flag && !out_en));

   assert_hot_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (therm_flag && !cool) |=> therm_flag);

   assert_idle_when_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!en || therm_flag) |=> (st == ST_RUN));

endmodule

bind ovl_guard ovl_guard_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .en         (en_s),
   .stat       (stat_s),
   .ovl        (ovl_s),
   .hot        (hot_s),
   .cool       (cool_s),
   .st         (st_q),
   .win_end    (win_end),
   .out_en     (out_en),
   .ovl_flag   (ovl_flag),
   .therm_flag (therm_flag)
);

// File: tb/test_ovl_guard.sv
module test_ovl_guard;

   localparam int OFF = 40;
   localparam int DIV = 10;
   localparam int ON  = OFF / DIV;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_en = 1'b0, clamp_static = 1'b0, ovl_det = 1'b0;
   logic temp_hot = 1'b0, temp_cool = 1'b0;
   logic out_en, ovl_flag, therm_flag;

   int total = 0;
   int bad   = 0;
   bit ended = 1'b0;

   always #2 clk = ~clk;

   ovl_guard #(.OFF_CYC(OFF), .ON_DIV(DIV), .SYNC_STAGES(0)) i_ovl_guard (
      .clk          (clk),
      .rst_n        (rst_n),
      .pwr_en       (pwr_en),
      .clamp_static (clamp_static),
      .ovl_det      (ovl_det),
      .temp_hot     (temp_hot),
      .temp_cool    (temp_cool),
      .out_en       (out_en),
      .ovl_flag     (ovl_flag),
      .therm_flag   (therm_flag)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic got, input logic exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%0d exp=%0d", req, got, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   task automatic t_reset();
      step(3);
      check("R1 out_en in reset", out_en, 1'b0);
      check("R1 ovl_flag in reset", ovl_flag, 1'b0);
      check("R1 therm_flag in reset", therm_flag, 1'b0);
      rst_n = 1'b1;
      step(1);
      check("R1 out_en after reset", out_en, 1'b0);
      pwr_en = 1'b1;
      step(1);
      check("R2 out_en enabled", out_en, 1'b1);
      check("R2 ovl_flag enabled", ovl_flag, 1'b0);
   endtask

   task automatic t_dyn_clean();
      ovl_det = 1'b1;
      step(1);
      ovl_det = 1'b0;
      check("R3 out_en off first", out_en, 1'b0);
      check("R3 flag set", ovl_flag, 1'b1);
      step(OFF - 1);
      check("R3 out_en off last", out_en, 1'b0);
      check("R3 flag during off", ovl_flag, 1'b1);
      step(1);
      check("R4 out_en trial start", out_en, 1'b1);
      check("R4 flag trial start", ovl_flag, 1'b1);
      step(ON - 1);
      check("R4 out_en trial end", out_en, 1'b1);
      check("R4 flag trial end", ovl_flag, 1'b1);
      step(1);
      check("R5 flag cleared", ovl_flag, 1'b0);
      check("R5 out_en kept", out_en, 1'b1);
   endtask

   task automatic t_dyn_persist();
      ovl_det = 1'b1;
      step(1);
      step(OFF);
      check("R4 out_en retry with fault", out_en, 1'b1);
      step(ON);
      check("R6 out_en off again", out_en, 1'b0);
      check("R6 flag held", ovl_flag, 1'b1);
      ovl_det = 1'b0;
      step(OFF + ON);
      check("R5 recovered flag", ovl_flag, 1'b0);
      check("R5 recovered out", out_en, 1'b1);
   endtask

   task automatic t_dyn_glitch();
      ovl_det = 1'b1;
      step(1);
      ovl_det = 1'b0;
      step(OFF);
      ovl_det = 1'b1;
      step(1);
      ovl_det = 1'b0;
      check("R6 out_en during window", out_en, 1'b1);
      step(ON - 1);
      check("R6 early pulse retriggers", out_en, 1'b0);
      step(OFF + ON);
      check("R5 flag after glitch recovery", ovl_flag, 1'b0);
   endtask

   task automatic t_static();
      clamp_static = 1'b1;
      step(1);
      ovl_det = 1'b1;
      step(1);
      check("R7 flag follows", ovl_flag, 1'b1);
      check("R7 out_en kept", out_en, 1'b1);
      step(5);
      check("R7 out_en held", out_en, 1'b1);
      ovl_det = 1'b0;
      step(1);
      check("R7 flag clears", ovl_flag, 1'b0);
      clamp_static = 1'b0;
      step(1);
   endtask

   task automatic t_switch();
      ovl_det = 1'b1;
      step(1);
      ovl_det = 1'b0;
      step(3);
      check("R8 off before switch", out_en, 1'b0);
      clamp_static = 1'b1;
      step(1);
      check("R8 out_en after switch", out_en, 1'b1);
      check("R8 flag after switch", ovl_flag, 1'b0);
      clamp_static = 1'b0;
      step(1);
   endtask

   task automatic t_therm();
      temp_hot = 1'b1;
      step(1);
      temp_hot = 1'b0;
      check("R9 therm set", therm_flag, 1'b1);
      check("R9 out_en off", out_en, 1'b0);
      step(3);
      check("R9 therm held", therm_flag, 1'b1);
      ovl_det = 1'b1;
      step(1);
      ovl_det = 1'b0;
      temp_cool = 1'b1;
      step(1);
      temp_cool = 1'b0;
      check("R9 therm cleared", therm_flag, 1'b0);
      check("R10 out_en after cool", out_en, 1'b1);
      check("R10 no overload cycle", ovl_flag, 1'b0);
      temp_hot = 1'b1;
      temp_cool = 1'b1;
      step(1);
      check("R9 hot wins", therm_flag, 1'b1);
      temp_hot = 1'b0;
      step(1);
      temp_cool = 1'b0;
      check("R9 cool clears", therm_flag, 1'b0);
   endtask

   task automatic t_enable();
      ovl_det = 1'b1;
      step(1);
      ovl_det = 1'b0;
      pwr_en = 1'b0;
      #1;
      check("R2 out_en drops at once", out_en, 1'b0);
      step(1);
      check("R2 cycle abandoned", ovl_flag, 1'b0);
      ovl_det = 1'b1;
      step(1);
      ovl_det = 1'b0;
      pwr_en = 1'b1;
      step(1);
      check("R10 out_en after enable", out_en, 1'b1);
      check("R10 flag after enable", ovl_flag, 1'b0);
   endtask

   initial begin
      t_reset();
      t_dyn_clean();
      t_dyn_persist();
      t_dyn_glitch();
      t_static();
      t_switch();
      t_therm();
      t_enable();
      finish_run();
   end

   initial begin
      #(4 * 200000);
      total++;
      bad++;
      $display("FAIL watchdog got=1 exp=0");
      finish_run();
   end

endmodule